// File: doc/BRIEF.md
# Self-Checking Lookup Table with Remapped Second Read

This block is a configurable 4-input lookup table that detects single-bit upsets in its own truth-table storage without keeping a second copy of it. The 16 stored bits form two 3-input halves. The top input selects which half drives the output. Every cycle, the selected half is read at two addresses: the normal address made from the three low inputs, and a mapped address. The mapped address is the normal address with a configured inversion mask applied.

Each half is configured for one of two relations between its two reads. In "same" mode the two reads must be equal. In "invert" mode they must be complementary. The function is chosen so that the relation holds for every input. A flipped storage bit then breaks the relation as soon as an input reads that bit against an intact partner, and a registered error flag rises on the next clock. A sticky copy of the flag is held until it is cleared.

The whole configuration is a 24-bit word, loaded one bit per clock. A test-only port can toggle any single truth-table bit, so that detection can be exercised.

Top module: `lut4_remap_guard`

## Requirements
- R1: The configuration is a 24-bit word, shifted in most-significant bit first on `cfg_sdi` while `cfg_load` is high, one bit per rising clock edge. Bits 15:0 are the truth table, indexed by `lut_in`. Bits 18:16 are the inversion mask of the lower half (`lut_in[3]`=0) and bit 19 is its mode. Bits 22:20 are the mask of the upper half and bit 23 is its mode. Mode 0 means the two reads must be equal; mode 1 means they must be complementary.
- R2: `lut_out` equals table bit `lut_in` combinationally, in the same cycle as the input.
- R3: On the clock edge after an input is applied, `err_flag` is 1 exactly when the selected half breaks its relation. The selected half is the one chosen by `lut_in[3]`; the relation compares table bit {`lut_in[3]`, a} with table bit {`lut_in[3]`, a XOR mask}, where a = `lut_in[2:0]`.
- R4: When the table satisfies both configured relations, `err_flag` stays 0 for every one of the 16 inputs.
- R5: When a half's mask is 000 and its mode is 0, both reads hit the same cell, and `err_flag` stays 0 for that half even after one of its bits has been flipped.
- R6: While `cfg_load` is high, `err_flag` is registered as 0 and `err_sticky` is not set.
- R7: `err_sticky` is set together with `err_flag` and stays set until `err_clr` is high on a clock edge. A clear takes priority over a new error on the same edge.
- R8: A clock edge with `flip_en` high and `cfg_load` low toggles table bit `flip_idx`. The change is visible on `lut_out` and persists until the bit is toggled again or reloaded.
- R9: Reset clears the configuration to all zeros and both error outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_sdi | input | 1 | Serial configuration data, MSB first |
| err_clr | input | 1 | Clears the sticky error bit |
| lut_in | input | 4 | Logic inputs; bit 3 selects the half |
| flip_en | input | 1 | Test-only: toggle one table bit |
| flip_idx | input | 4 | Test-only: index of the bit to toggle |
| lut_out | output | 1 | Function output |
| err_flag | output | 1 | Registered relation-failure flag |
| err_sticky | output | 1 | Held error bit |

## Verification
On every cycle, the assertions check how the flag timing relates to the gated failure event. They also check the load masking, the self-mapped quiet case, and the hold-and-clear behaviour of the sticky bit. Whether a given upset is actually exposed depends on the table contents, the mask and the input. The bench's sweeps show this: they cover every nonzero mask in both modes, flip each of the 16 stored bits in turn, and compare the flag with a relation computed independently in the bench.

// File: rtl/lut_remap_pkg.sv
package lut_remap_pkg;

  typedef enum logic {
    REL_SAME   = 1'b0,
    REL_INVERT = 1'b1
  } rel_mode_e;

  // True when the two reads of one half violate the configured relation.
  function automatic logic relation_broken(input logic v_norm,
                                           input logic v_map,
                                           input rel_mode_e mode);
    logic differ;
    differ = v_norm ^ v_map;
    return (mode == REL_SAME) ? differ : ~differ;
  endfunction

  // Count of stored bits for a table with the given input count.
  function automatic int table_bits(input int n_in);
    return 1 << n_in;
  endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int CFG_W = 24,
  parameter int TBL_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             sdi,
  input  logic             flip_en,
  input  logic [IDX_W-1:0] flip_idx,
  output logic [CFG_W-1:0] cfg_q
);

  logic [CFG_W-1:0] flip_mask;

  always_comb begin
    flip_mask = '0;
    for (int i = 0; i < TBL_W; i++) begin
      if (flip_idx == IDX_W'(i)) flip_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= {cfg_q[CFG_W-2:0], sdi};
    end else if (flip_en) begin
      cfg_q <= cfg_q ^ flip_mask;
    end
  end

endmodule

// File: rtl/remap_half.sv
module remap_half
  import lut_remap_pkg::*;
#(
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic [DEPTH-1:0] tbl,
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    mask,
  input  rel_mode_e        mode,
  output logic             rd_norm,
  output logic             broken
);

  logic [AW-1:0] map_addr;
  logic          rd_map;

  assign map_addr = addr ^ mask;
  assign rd_norm  = tbl[addr];
  assign rd_map   = tbl[map_addr];
  assign broken   = relation_broken(rd_norm, rd_map, mode);

endmodule

// File: rtl/err_track.sv
module err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  input  logic broken,
  output logic fail_gated,
  output logic err_flag,
  output logic err_sticky
);

  assign fail_gated = broken & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag   <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_flag <= fail_gated;
      if (clr)             err_sticky <= 1'b0;
      else if (fail_gated) err_sticky <= 1'b1;
    end
  end

endmodule

// File: rtl/lut4_remap_guard.sv
module lut4_remap_guard
  import lut_remap_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int HALF_AW = N_IN - 1,
  localparam int HALF_D  = 1 << HALF_AW,
  localparam int TBL_W   = 2 * HALF_D,
  localparam int MAP_W   = HALF_AW + 1,
  localparam int CFG_W   = TBL_W + 2 * MAP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_sdi,
  input  logic            err_clr,
  input  logic [N_IN-1:0] lut_in,
  input  logic            flip_en,
  input  logic [N_IN-1:0] flip_idx,
  output logic            lut_out,
  output logic            err_flag,
  output logic            err_sticky
);

  logic [CFG_W-1:0]   cfg_q;
  logic [1:0]         half_out;
  logic [1:0]         half_broken;
  logic [HALF_AW-1:0] half_mask [2];
  rel_mode_e          half_mode [2];

  logic               sel;
  logic [HALF_AW-1:0] sel_mask;
  logic               sel_comp;
  logic               sel_broken;
  logic               fail_gated;

  cfg_chain #(
    .CFG_W (CFG_W),
    .TBL_W (TBL_W),
    .IDX_W (N_IN)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .sdi      (cfg_sdi),
    .flip_en  (flip_en),
    .flip_idx (flip_idx),
    .cfg_q    (cfg_q)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int MAP_LSB = TBL_W + h * MAP_W;

    assign half_mask[h] = cfg_q[MAP_LSB +: HALF_AW];
    assign half_mode[h] = rel_mode_e'(cfg_q[MAP_LSB + HALF_AW]);

    remap_half #(
      .AW (HALF_AW)
    ) u_half (
      .tbl     (cfg_q[h*HALF_D +: HALF_D]),
      .addr    (lut_in[HALF_AW-1:0]),
      .mask    (half_mask[h]),
      .mode    (half_mode[h]),
      .rd_norm (half_out[h]),
      .broken  (half_broken[h])
    );
  end

  assign sel        = lut_in[N_IN-1];
  assign lut_out    = half_out[sel];
  assign sel_broken = half_broken[sel];
  assign sel_mask   = half_mask[sel];
  assign sel_comp   = (half_mode[sel] == REL_INVERT);

  err_track u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .clr        (err_clr),
    .broken     (sel_broken),
    .fail_gated (fail_gated),
    .err_flag   (err_flag),
    .err_sticky (err_sticky)
  );

endmodule

// File: rtl/lut_remap_chk.sv
module lut_remap_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          err_clr,
  input logic          err_flag,
  input logic          err_sticky,
  input logic          fail_gated,
  input logic [AW-1:0] sel_mask,
  input logic          sel_comp
);

  // R3
  flag_follows_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_gated |=> err_flag);

  // R3
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_gated |=> !err_flag);

  // R6
  load_masks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !err_flag);

  // R6
  load_keeps_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !err_sticky) |=> !err_sticky);

  // R5
  self_map_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0 && !sel_comp && !cfg_load) |=> !err_flag);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_sticky);

  // R7
  sticky_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_gated && !err_clr) |=> (err_flag && err_sticky));

endmodule

bind lut4_remap_guard lut_remap_chk #(
  .AW (HALF_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .err_clr    (err_clr),
  .err_flag   (err_flag),
  .err_sticky (err_sticky),
  .fail_gated (fail_gated),
  .sel_mask   (sel_mask),
  .sel_comp   (sel_comp)
);

// File: tb/lut4_remap_guard_bench.sv
module lut4_remap_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic       cfg_sdi = 1'b0;
  logic       err_clr = 1'b0;
  logic [3:0] lut_in = '0;
  logic       flip_en = 1'b0;
  logic [3:0] flip_idx = '0;
  logic       lut_out, err_flag, err_sticky;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] tbl;
  logic [2:0]  m0, m1;
  logic        c0, c1;

  always #10 clk = ~clk;

  lut4_remap_guard u_lut4_remap_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_sdi    (cfg_sdi),
    .err_clr    (err_clr),
    .lut_in     (lut_in),
    .flip_en    (flip_en),
    .flip_idx   (flip_idx),
    .lut_out    (lut_out),
    .err_flag   (err_flag),
    .err_sticky (err_sticky)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic exp_fail(input logic [3:0] x);
    logic [2:0] a, m;
    logic       c, v, w;
    a = x[2:0];
    m = x[3] ? m1 : m0;
    c = x[3] ? c1 : c0;
    v = tbl[{x[3], a}];
    w = tbl[{x[3], a ^ m}];
    return c ? (v == w) : (v != w);
  endfunction

  // R1: MSB first, one bit per edge, quiet-flag check during the shift (R6)
  task automatic load_word(input logic [23:0] word);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk);
      if (i < 23) begin
        check1("R6 flag low while loading", err_flag, 1'b0);
        check1("R6 sticky not set while loading", err_sticky, 1'b0);
      end
      cfg_load = 1'b1;
      cfg_sdi  = word[i];
    end
    @(negedge clk);
    cfg_load = 1'b0;
    tbl = word[15:0];
    m0 = word[18:16]; c0 = word[19];
    m1 = word[22:20]; c1 = word[23];
  endtask

  task automatic flip_bit(input logic [3:0] idx, input logic clr);
    @(negedge clk);
    flip_en = 1'b1; flip_idx = idx; err_clr = clr;
    @(negedge clk);
    flip_en = 1'b0; err_clr = 1'b0;
    tbl[idx] = ~tbl[idx];
  endtask

  task automatic sweep_inputs();
    logic [3:0] prev;
    prev = '0;
    for (int x = 0; x < 16; x++) begin
      @(negedge clk);
      if (x > 0) check1("R4 no false alarm", err_flag, exp_fail(prev));
      lut_in = 4'(x);
      prev   = 4'(x);
      #1 check1("R1/R2 function output", lut_out, tbl[x]);
    end
    @(negedge clk);
    check1("R4 no false alarm", err_flag, exp_fail(prev));
    check1("R4 sticky stays clear", err_sticky, 1'b0);
  endtask

  function automatic logic [7:0] build_half(input logic [2:0] m, input logic c);
    logic [2:0] k;
    logic [7:0] t;
    k = 3'd1;
    for (int j = 1; j < 8; j++) begin
      if ((^(m & 3'(j))) == c) begin
        k = 3'(j);
        break;
      end
    end
    for (int a = 0; a < 8; a++) t[a] = ^(3'(a) & k);
    return t;
  endfunction

  initial begin
    tbl = '0; m0 = '0; m1 = '0; c0 = 1'b0; c1 = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check1("R9 flag low in reset", err_flag, 1'b0);
    check1("R9 sticky low in reset", err_sticky, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int x = 0; x < 16; x++) begin
      lut_in = 4'(x);
      #1 check1("R9 cleared table", lut_out, 1'b0);
    end
    @(negedge clk);
    check1("R9 no error after reset", err_flag, 1'b0);

    // Sweep every nonzero mask in both modes
    for (int m = 1; m < 8; m++) begin
      for (int c = 0; c < 2; c++) begin
        logic [7:0]  h0;
        logic [2:0]  mb;
        logic [23:0] word;
        mb = 3'(m);
        h0 = build_half(mb, c[0]);
        word = {c[0], mb, c[0], mb, ~h0, h0};
        load_word(word);
        sweep_inputs();
        for (int idx = 0; idx < 16; idx++) begin
          logic [3:0] ib;
          ib = 4'(idx);
          flip_bit(ib, 1'b0);
          lut_in = ib;
          #1 check1("R8 flipped bit visible", lut_out, tbl[ib]);
          @(negedge clk);
          check1("R3 upset detected", err_flag, exp_fail(ib));
          check1("R7 sticky set", err_sticky, 1'b1);
          lut_in = {~ib[3], 3'b000};
          @(negedge clk);
          check1("R3 intact half quiet", err_flag, exp_fail(lut_in));
          check1("R7 sticky held", err_sticky, 1'b1);
          flip_bit(ib, 1'b1);
          check1("R7 sticky cleared", err_sticky, 1'b0);
          check1("R8 restored flag", err_flag, 1'b0);
        end
      end
    end

    // R5: mask 000 in same mode hides every upset
    load_word({4'b0000, 4'b0000, 16'hA5C3});
    for (int idx = 0; idx < 16; idx++) begin
      logic [3:0] ib;
      ib = 4'(idx);
      flip_bit(ib, 1'b0);
      lut_in = ib;
      #1 check1("R5 self-map output follows flip", lut_out, tbl[ib]);
      @(negedge clk);
      check1("R5 self-map upset silent", err_flag, 1'b0);
      check1("R5 self-map sticky silent", err_sticky, 1'b0);
      flip_bit(ib, 1'b0);
    end

    // R6: a load starting while an error is shown masks the flag
    begin
      logic [7:0] h0;
      h0 = build_half(3'b101, 1'b0);
      load_word({1'b0, 3'b101, 1'b0, 3'b101, h0, h0});
      flip_bit(4'd2, 1'b0);
      lut_in = 4'd2;
      @(negedge clk);
      check1("R3 error before load", err_flag, 1'b1);
      err_clr = 1'b1;
      cfg_load = 1'b1;
      cfg_sdi = 1'b0;
      @(negedge clk);
      err_clr = 1'b0;
      check1("R6 flag masked at load start", err_flag, 1'b0);
      check1("R7 clear wins over load", err_sticky, 1'b0);
      load_word({1'b0, 3'b101, 1'b0, 3'b101, h0, h0});
      check1("R6 reload sticky still clear", err_sticky, 1'b0);
      @(negedge clk);
      check1("R1 reloaded table consistent", err_flag, exp_fail(lut_in));
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule